// File: doc/BRIEF.md
# Local-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using only the outcomes of earlier runs of that same branch. The prediction takes two lookups in a row. A few low bits of the branch address pick one of several small shift registers, and each of these holds the recent taken/not-taken pattern of the branches that map to it. That pattern then picks one 2-bit saturating counter. The counter's upper bit is the guess.

A fetch stage puts the branch address on the predict port and reads the direction back in the same cycle, since the path is purely combinational. When the branch resolves, the execute stage sends the address and the real outcome on the update port. On that clock edge the counter selected by the branch's current pattern is trained, and the outcome is shifted into the branch's pattern register. The counter table is indexed only by the pattern, so any branches whose pattern is the same share the same counters.

Top module: `local_hist_predictor`

## Requirements
- R1: After reset, every history register is zero and every counter holds 01 (weakly not taken), so every address predicts not taken.
- R2: Address bits [ALIGN+SEL_W-1:ALIGN] (bits 5:2 by default) select the history register. Two addresses that agree in those bits share one history register.
- R3: `pred_taken` is bit 1 of the counter indexed by the selected history value. Counter values 10 and 11 predict taken. The counter table is indexed only by the history value, never by the address.
- R4: On an update, the outcome (1 = taken) enters bit 0 of the selected history register, the older bits move up by one position, and the oldest bit is dropped.
- R5: An update trains the counter indexed by the history value as it was before the update. A taken outcome adds one and a not-taken outcome subtracts one.
- R6: Counters saturate at 11 and at 00. A counter in a strong state keeps its predicted direction after one contrary outcome.
- R7: When a predict and an update arrive in the same cycle, the prediction comes from the state before the update. The updated state is visible from the next cycle on.
- R8: While `upd_valid` is low, no history register or counter changes, whatever values `upd_pc` and `upd_taken` carry.
- R9: Asserting reset in the middle of operation returns the block to the state described in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Marks a resolved branch to train on |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest behaviour to reach is the sharing of counters between different branches. From the ports this only shows up when one branch's history happens to equal a pattern that another branch has already trained. The stimulus sets this up on purpose. One branch trains the counter for the all-zero pattern, and a second, untouched branch then reads that counter as taken. The same effect shows whether an update was ignored: an update that leaked through with `upd_valid` low would decrement that shared counter and flip the second branch's prediction. Saturation is reached by repeating one branch until its history is all ones.

// File: rtl/local_hist_predictor.sv
module local_hist_predictor #(
  parameter int PC_W   = 32,
  parameter int ALIGN  = 2,
  parameter int SEL_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int N_HIST = 1 << SEL_W;
  localparam int N_CTR  = 1 << HIST_W;

  logic [N_HIST-1:0][HIST_W-1:0] hist_q;
  logic [N_CTR-1:0][1:0]         ctr_q;

  wire [SEL_W-1:0]  p_sel = SEL_W'(pred_pc >> ALIGN);
  wire [SEL_W-1:0]  u_sel = SEL_W'(upd_pc >> ALIGN);
  wire [HIST_W-1:0] p_pat = hist_q[p_sel];
  wire [HIST_W-1:0] u_pat = hist_q[u_sel];
  wire [1:0]        u_ctr = ctr_q[u_pat];

  logic [1:0] u_ctr_nxt;
  always_comb begin
    u_ctr_nxt = u_ctr;
    if (upd_taken && u_ctr != 2'b11)       u_ctr_nxt = u_ctr + 2'd1;
    else if (!upd_taken && u_ctr != 2'b00) u_ctr_nxt = u_ctr - 2'd1;
  end

  assign pred_taken = ctr_q[p_pat][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_HIST; i++) hist_q[i] <= '0;
      for (int j = 0; j < N_CTR; j++)  ctr_q[j]  <= 2'b01;
    end else if (upd_valid) begin
      ctr_q[u_pat]  <= u_ctr_nxt;
      hist_q[u_sel] <= {u_pat[HIST_W-2:0], upd_taken};
    end
  end
endmodule

// File: rtl/local_hist_predictor_chk.sv
module local_hist_predictor_chk #(
  parameter int SEL_W  = 4,
  parameter int HIST_W = 4
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                upd_valid,
  input logic                                upd_taken,
  input logic [SEL_W-1:0]                    u_sel,
  input logic [HIST_W-1:0]                   u_pat,
  input logic [(1<<SEL_W)-1:0][HIST_W-1:0]   hist_q,
  input logic [(1<<HIST_W)-1:0][1:0]         ctr_q
);
  AST_HIST_NEWBIT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> hist_q[$past(u_sel)][0] == $past(upd_taken)); // R4

  AST_CTR_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && ctr_q[u_pat] != 2'b11)
    |=> ctr_q[$past(u_pat)] == $past(ctr_q[u_pat]) + 2'd1); // R5

  AST_CTR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && ctr_q[u_pat] != 2'b00)
    |=> ctr_q[$past(u_pat)] == $past(ctr_q[u_pat]) - 2'd1); // R5

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && ctr_q[u_pat] == 2'b11)
    |=> ctr_q[$past(u_pat)] == 2'b11); // R6

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && ctr_q[u_pat] == 2'b00)
    |=> ctr_q[$past(u_pat)] == 2'b00); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && $past(rst_n)) |=> ($stable(hist_q) && $stable(ctr_q))); // R8
endmodule

bind local_hist_predictor local_hist_predictor_chk #(.SEL_W(SEL_W), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .u_sel(u_sel), .u_pat(u_pat), .hist_q(hist_q), .ctr_q(ctr_q)
);

// File: tb/local_hist_predictor_tb.sv
module local_hist_predictor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  local_hist_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  // entry = {expected prediction, update valid, outcome, pc[7:0]}
  localparam int NV = 20;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,8'h10}, {1'b0,1'b1,1'b1,8'h10}, {1'b0,1'b1,1'b1,8'h10},
    {1'b0,1'b1,1'b1,8'h10}, {1'b0,1'b1,1'b1,8'h10}, {1'b1,1'b1,1'b1,8'h10},
    {1'b1,1'b1,1'b1,8'h10}, {1'b1,1'b1,1'b0,8'h10}, {1'b1,1'b1,1'b0,8'h14},
    {1'b0,1'b1,1'b0,8'h14}, {1'b0,1'b1,1'b0,8'h14}, {1'b0,1'b1,1'b1,8'h14},
    {1'b0,1'b1,1'b1,8'h10}, {1'b0,1'b1,1'b0,8'h10}, {1'b1,1'b1,1'b1,8'h14},
    {1'b0,1'b1,1'b1,8'h50}, {1'b0,1'b0,1'b1,8'h10}, {1'b0,1'b1,1'b0,8'h10},
    {1'b1,1'b1,1'b1,8'h14}, {1'b1,1'b0,1'b0,8'h14}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; upd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state predicts not taken everywhere
    for (int k = 0; k < 4; k++) begin
      pred_pc = 32'h100 + 32'(k*4);
      #2 chk("R1 reset predicts not taken", pred_taken, 1'b0);
    end

    // R2 R3 R4 R5 R6: table walk (0x50 aliases 0x10 in bits 5:2)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pred_pc   = {24'h0, VEC[i][7:0]};
      upd_pc    = {24'h0, VEC[i][7:0]};
      upd_taken = VEC[i][8];
      upd_valid = VEC[i][9];
      #2 chk("R2/R3/R4/R5/R6 vector", pred_taken, VEC[i][10]);
    end
    @(negedge clk); upd_valid = 1'b0;

    // R9: reset mid-run clears trained state
    do_reset();
    pred_pc = 32'h10; #2 chk("R9 reset clears branch 0x10", pred_taken, 1'b0);
    pred_pc = 32'h14; #2 chk("R9 reset clears branch 0x14", pred_taken, 1'b0);

    // R7: same-cycle predict and update of one branch
    @(negedge clk);
    pred_pc = 32'h10; upd_pc = 32'h10; upd_taken = 1'b1; upd_valid = 1'b1;
    #2 chk("R7 pre-update prediction", pred_taken, 1'b0);
    @(negedge clk);
    upd_valid = 1'b0;
    pred_pc = 32'h14;
    #2 chk("R7 update visible next cycle via shared counter", pred_taken, 1'b1);

    // R8: invalid updates that would decrement the shared counter
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      upd_valid = 1'b0; upd_pc = 32'h14; upd_taken = 1'b0;
    end
    @(negedge clk);
    pred_pc = 32'h14;
    #2 chk("R8 ignored update leaves counter", pred_taken, 1'b1);
    pred_pc = 32'h10;
    #2 chk("R8 ignored update leaves other branch", pred_taken, 1'b0);

    // R6: two contrary outcomes needed to leave strong taken
    @(negedge clk);
    upd_pc = 32'h14; upd_taken = 1'b1; upd_valid = 1'b1; // ctr0 -> 11, hist14=0001
    @(negedge clk);
    upd_pc = 32'h18; upd_taken = 1'b0; upd_valid = 1'b1; // ctr0 -> 10
    @(negedge clk);
    upd_valid = 1'b0; pred_pc = 32'h1C;
    #2 chk("R6 strong survives one contrary", pred_taken, 1'b1);
    @(negedge clk);
    upd_pc = 32'h1C; upd_taken = 1'b0; upd_valid = 1'b1; // ctr0 -> 01
    @(negedge clk);
    upd_valid = 1'b0; pred_pc = 32'h20;
    #2 chk("R6 flips after second contrary", pred_taken, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule